// File: doc/BRIEF.md
# Serial Shadow-RAM Command Controller

This block is a slave on a three-wire serial link made of a chip-enable, a serial clock and a serial data input. It holds a 16-word by 16-bit working RAM and a same-sized modelled nonvolatile shadow array. Framed 8-bit commands can write or read a RAM word, set or clear a write-enable latch, copy the RAM into the shadow array (store), or copy the shadow array into the RAM (recall). Two active-low pins can also start a store or a recall without any serial traffic.

The serial pins are brought into the system clock domain through synchronizers, and their edges are detected there, so the serial clock may run slowly, stop and restart at any time. A store or recall holds a busy output high for a fixed number of system clocks and then copies all words at once. Two latches protect the shadow data. Writes need the write-enable latch. Stores need that latch and also the previous-recall latch, which only an explicit recall sets.

Top module: `shadow_ram_ctrl`

## Requirements
- R1: After reset, busy and ser_dout are 0, both latches are clear, and RAM and shadow word i both hold 0xA5C3 XOR (i * 0x0111), truncated to 16 bits.
- R2: While ser_en is high and no frame has started, samples of ser_din that are 0 are ignored. The first 1 sampled on a serial clock rising edge is bit 7 of the command.
- R3: A command is 8 bits, sent MSB first and sampled on serial clock rising edges. Bit 7 is 1, bits 6..3 hold the word address, and bits 2..0 hold the opcode (000 clear write-enable, 001 store, 010 reserved, 011 write, 100 set write-enable, 101 recall, 11x read). For a read, the addressed word appears MSB first on ser_dout. Bit 15 appears after the first falling edge that follows the 8th rising edge, and each later falling edge presents the next lower bit.
- R4: A write changes the RAM only while the write-enable latch is set. With the latch clear, the addressed word keeps its value.
- R5: Opcode 000 clears the write-enable latch, so a later write has no effect.
- R6: A store request is dropped unless both the write-enable latch and the previous-recall latch are set. The recall done at reset does not set the previous-recall latch.
- R7: An accepted store holds busy high for exactly BUSY_CYCLES system clocks, then copies every RAM word into the shadow array and clears the write-enable latch.
- R8: A recall, started by opcode 101 or by a falling edge on recall_n, raises busy for BUSY_CYCLES clocks, then copies every shadow word into the RAM. It also sets the previous-recall latch.
- R9: After a write command, each rising edge shifts one data bit into a 16-bit register that was cleared at the start of the data phase. On the fall of ser_en, if at least one data bit arrived, the register is written to the addressed word. A short frame therefore leaves its k bits in the low positions, and a long frame keeps the last 16 bits.
- R10: While busy is high, commands, writes and pin requests have no effect.
- R11: If a store request and a recall request arrive in the same cycle, only the recall runs, and the write-enable latch keeps its value.
- R12: The reserved opcode 010 changes nothing. In particular it leaves the write-enable latch as it was.
- R13: A fall of ser_en in the middle of a command returns the decoder to waiting for a start bit, and the partial command is not executed.
- R14: Holding the serial clock still in the middle of a frame freezes the frame. The frame resumes correctly when the clock restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Serial chip enable, active high |
| ser_clk | input | 1 | Serial clock, asynchronous and static |
| ser_din | input | 1 | Serial data input |
| store_n | input | 1 | Active-low store request pin |
| recall_n | input | 1 | Active-low recall request pin |
| ser_dout | output | 1 | Serial read data output |
| busy | output | 1 | High while a store or recall runs |

## Verification
Store and recall requests can collide in one system clock. This can be a store pin fall together with a recall pin fall, or either one together with a decoded command or a pending RAM write. The bench drives both pins low on the same clock edge so that their synchronized falls line up. It then judges the outcome through the ports. A read of a word that was changed beforehand must return the shadow value, and a following write must still succeed, which shows that no store cleared the write-enable latch. A second collision puts a command frame inside a busy window, and a later write shows that the command was inhibited.

// File: rtl/shram_pkg.sv
// Package: shared opcode and transfer types for the shadow-RAM controller.
// Assumes the three opcode bits sit at the bottom of the command byte.
package shram_pkg;
    typedef enum logic [2:0] {
        OPC_WRDS  = 3'b000,
        OPC_STORE = 3'b001,
        OPC_RSVD  = 3'b010,
        OPC_WRITE = 3'b011,
        OPC_WREN  = 3'b100,
        OPC_RCL   = 3'b101,
        OPC_RD0   = 3'b110,
        OPC_RD1   = 3'b111
    } opc_e;

    typedef enum logic {
        XF_STORE  = 1'b0,
        XF_RECALL = 1'b1
    } xfer_e;
endpackage

// File: rtl/shram_sync.sv
// Module: multi-stage synchronizer for asynchronous pins.
// Assumes the inputs are slow compared with clk; each bit is treated independently.
module shram_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw pin values through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign lvl = stg[STAGES-1];
endmodule

// File: rtl/shram_edge.sv
// Module: change detector; flags a cycle in which a synchronized level toggled.
// Assumes the caller combines the flag with the level to tell rise from fall.
module shram_edge #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev;

    // Keep the previous level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign chg = lvl ^ prev;
endmodule

// File: rtl/shram_decoder.sv
// Module: serial frame decoder. Waits for a start '1', collects the command,
// shifts write data in and read data out, and reports commands to the core.
// Assumes sk_rise/sk_fall are single-cycle strobes at least three clk apart.
module shram_decoder
    import shram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              di_s,
    input  logic              sk_rise,
    input  logic              sk_fall,
    input  logic [DATA_W-1:0] rd_word,
    output logic              cmd_valid,
    output opc_e              cmd_opc,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_commit,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout
);
    localparam int IR_W  = ADDR_W + 4;
    localparam int CNT_W = $clog2(IR_W);

    typedef enum logic [2:0] {
        ST_IDLE, ST_INSTR, ST_WDATA, ST_RLOAD, ST_RDATA, ST_HOLD
    } dec_st_e;

    dec_st_e            st;
    logic [IR_W-3:0]    ir_q;
    logic [IR_W-2:0]    ir_next;
    logic [CNT_W-1:0]   bit_cnt;
    logic               got_bit;
    logic [DATA_W-1:0]  rsr;

    // Command bits after the start bit, including the one sampled now.
    assign ir_next = {ir_q, di_s};

    // Frame state machine, shift registers and command strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ir_q      <= '0;
            bit_cnt   <= '0;
            got_bit   <= 1'b0;
            rsr       <= '0;
            dout      <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_opc   <= OPC_RSVD;
            addr_q    <= '0;
            wr_commit <= 1'b0;
            wr_data   <= '0;
        end else begin
            cmd_valid <= 1'b0;
            wr_commit <= 1'b0;
            if (!ce_s) begin
                if (st == ST_WDATA && got_bit) wr_commit <= 1'b1;
                st      <= ST_IDLE;
                bit_cnt <= '0;
                dout    <= 1'b0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (sk_rise && di_s) begin
                            ir_q    <= '0;
                            bit_cnt <= '0;
                            st      <= ST_INSTR;
                        end
                    end
                    ST_INSTR: begin
                        if (sk_rise) begin
                            ir_q    <= ir_next[IR_W-3:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == CNT_W'(IR_W-2)) begin
                                addr_q  <= ir_next[IR_W-2 -: ADDR_W];
                                cmd_opc <= opc_e'(ir_next[2:0]);
                                if (ir_next[2:0] == OPC_WRITE) begin
                                    wr_data <= '0;
                                    got_bit <= 1'b0;
                                    st      <= ST_WDATA;
                                end else if (ir_next[2:1] == 2'b11) begin
                                    st <= ST_RLOAD;
                                end else begin
                                    cmd_valid <= 1'b1;
                                    st        <= ST_HOLD;
                                end
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (sk_rise) begin
                            wr_data <= {wr_data[DATA_W-2:0], di_s};
                            got_bit <= 1'b1;
                        end
                    end
                    ST_RLOAD: begin
                        rsr <= rd_word;
                        st  <= ST_RDATA;
                    end
                    ST_RDATA: begin
                        if (sk_fall) begin
                            dout <= rsr[DATA_W-1];
                            rsr  <= {rsr[DATA_W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R13: a low enable always leaves the decoder idle with a quiet output.
    a_r13_idle_after_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> (st == ST_IDLE && dout == 1'b0));

    // R9: a RAM write is only committed from an enable fall.
    a_r9_commit_on_ce_drop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !$past(ce_s));

    // R3: read data is driven only during the read data phase.
    a_r3_dout_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        dout |-> (st == ST_RDATA));
endmodule

// File: rtl/shram_core.sv
// Module: storage core. Holds the RAM, the shadow array, both protection
// latches and the busy timer of store/recall transfers.
// Assumes command and write strobes are single-cycle pulses from the decoder.
module shram_core
    import shram_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  opc_e              cmd_opc,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_commit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              store_fall,
    input  logic              recall_fall,
    output logic [DATA_W-1:0] rd_word,
    output logic              busy
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int BC_W  = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

    logic [WORDS-1:0][DATA_W-1:0] ram;
    logic [WORDS-1:0][DATA_W-1:0] shadow;
    logic              wel, prv;
    xfer_e             xop;
    logic [BC_W-1:0]   cnt;
    logic              recall_req, store_req, start_rcl, start_sto, done, wr_ok;

    // Factory contents loaded on a cold reset.
    function automatic logic [DATA_W-1:0] init_word(input int i);
        return DATA_W'(32'hA5C3 ^ (i * 32'h0111));
    endfunction

    // Request arbitration: recall wins over store, both win over writes.
    always_comb begin
        recall_req = (cmd_valid && cmd_opc == OPC_RCL) || recall_fall;
        store_req  = (cmd_valid && cmd_opc == OPC_STORE) || store_fall;
        start_rcl  = !busy && recall_req;
        start_sto  = !busy && !recall_req && store_req && wel && prv;
        done       = busy && (cnt == BC_W'(BUSY_CYCLES-1));
        wr_ok      = !busy && !start_rcl && !start_sto && wr_commit && wel;
    end

    // Latches and transfer timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            xop  <= XF_RECALL;
            wel  <= 1'b0;
            prv  <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (done) begin
                busy <= 1'b0;
                if (xop == XF_STORE) wel <= 1'b0;
            end
        end else if (start_rcl) begin
            busy <= 1'b1;
            cnt  <= '0;
            xop  <= XF_RECALL;
            prv  <= 1'b1;
        end else if (start_sto) begin
            busy <= 1'b1;
            cnt  <= '0;
            xop  <= XF_STORE;
        end else if (cmd_valid) begin
            if (cmd_opc == OPC_WREN) wel <= 1'b1;
            if (cmd_opc == OPC_WRDS) wel <= 1'b0;
        end
    end

    // RAM and shadow array: bulk copy at transfer end, single-word writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                ram[i]    <= init_word(i);
                shadow[i] <= init_word(i);
            end
        end else if (done) begin
            if (xop == XF_STORE) shadow <= ram;
            else                 ram    <= shadow;
        end else if (wr_ok) begin
            ram[addr] <= wr_data;
        end
    end

    assign rd_word = busy ? '0 : ram[addr];

    // R6: a store only begins when both latches were set.
    a_r6_store_needs_latches: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && xop == XF_STORE) |-> $past(wel && prv));

    // R7: the write-enable latch is clear once a store finishes.
    a_r7_wel_clear_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && xop == XF_STORE) |-> !wel);

    // R8: a finished recall leaves the previous-recall latch set.
    a_r8_prv_after_recall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && xop == XF_RECALL) |-> prv);

    // R10: the RAM does not change inside a busy window.
    a_r10_ram_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ram));

    // R5: an accepted clear-write-enable command leaves the latch clear.
    a_r5_wrds_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_opc == OPC_WRDS && !busy && !recall_fall && !store_fall)
        |-> !wel);
endmodule

// File: rtl/shadow_ram_ctrl.sv
// Module: top of the serial shadow-RAM controller. Synchronizes the pins,
// finds serial clock and request edges, and joins decoder and storage core.
// Assumes the serial clock half-period spans at least three clk cycles.
module shadow_ram_ctrl
    import shram_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int BUSY_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_en,
    input  logic ser_clk,
    input  logic ser_din,
    input  logic store_n,
    input  logic recall_n,
    output logic ser_dout,
    output logic busy
);
    logic [4:0]        lvl;
    logic [2:0]        chg;
    logic              sk_rise, sk_fall, store_fall, recall_fall;
    logic              cmd_valid, wr_commit;
    opc_e              cmd_opc;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wr_data, rd_word;

    shram_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11000)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({recall_n, store_n, ser_din, ser_en, ser_clk}),
        .lvl      (lvl)
    );

    shram_edge #(.W(3), .RST_VAL(3'b110)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({lvl[4], lvl[3], lvl[0]}),
        .chg   (chg)
    );

    // Turn toggles into directed edge strobes.
    always_comb begin
        sk_rise     = chg[0] &  lvl[0];
        sk_fall     = chg[0] & ~lvl[0];
        store_fall  = chg[1] & ~lvl[3];
        recall_fall = chg[2] & ~lvl[4];
    end

    shram_decoder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_s      (lvl[1]),
        .di_s      (lvl[2]),
        .sk_rise   (sk_rise),
        .sk_fall   (sk_fall),
        .rd_word   (rd_word),
        .cmd_valid (cmd_valid),
        .cmd_opc   (cmd_opc),
        .addr_q    (addr_q),
        .wr_commit (wr_commit),
        .wr_data   (wr_data),
        .dout      (ser_dout)
    );

    shram_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_opc     (cmd_opc),
        .addr        (addr_q),
        .wr_commit   (wr_commit),
        .wr_data     (wr_data),
        .store_fall  (store_fall),
        .recall_fall (recall_fall),
        .rd_word     (rd_word),
        .busy        (busy)
    );
endmodule

// File: tb/shadow_ram_ctrl_bench.sv
`timescale 1ns/1ps
module shadow_ram_ctrl_bench;
    localparam int BUSY = 300;
    localparam int HP   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
    logic store_n = 1'b1, recall_n = 1'b1;
    logic ser_dout, busy;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] m_ram [16];
    logic [15:0] m_sh  [16];
    bit m_wel, m_prv;

    always #2 clk = ~clk;

    shadow_ram_ctrl #(.BUSY_CYCLES(BUSY)) u_shadow_ram_ctrl (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_din(ser_din), .store_n(store_n), .recall_n(recall_n),
        .ser_dout(ser_dout), .busy(busy)
    );

    function automatic logic [15:0] init_w(input int i);
        return 16'(32'hA5C3 ^ (i * 32'h0111));
    endfunction

    function automatic logic [15:0] wr_expect(input logic [31:0] d, input int n);
        int k = (n > 16) ? 16 : n;
        return d[15:0] & 16'((32'd1 << k) - 1);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_clk = 1'b0; ser_din = v[i]; tick(HP);
            ser_clk = 1'b1; tick(HP);
        end
    endtask

    task automatic begin_frame();
        ser_clk = 1'b0; ser_en = 1'b1; tick(HP);
    endtask

    task automatic end_frame();
        ser_clk = 1'b0; tick(HP);
        ser_en = 1'b0; ser_din = 1'b0; tick(2 * HP);
    endtask

    task automatic do_cmd(input logic [2:0] op);
        begin_frame(); send_bits({24'd0, 5'b10000, op}, 8); end_frame();
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d, input int n);
        begin_frame(); send_bits({24'd0, 1'b1, a, 3'b011}, 8);
        if (n > 0) send_bits(d, n);
        end_frame();
    endtask

    task automatic do_read(input logic [3:0] a, input logic [15:0] exp, input string req);
        logic [15:0] w = '0;
        begin_frame(); send_bits({24'd0, 1'b1, a, 3'b110}, 8);
        for (int i = 0; i < 16; i++) begin
            ser_clk = 1'b0; tick(HP);
            w = {w[14:0], ser_dout};
            ser_clk = 1'b1; tick(HP);
        end
        end_frame();
        check(w == exp, req, {16'd0, w}, {16'd0, exp});
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin tick(1); g++; end
    endtask

    task automatic pins_measure(input bit st, input bit rc, output int len);
        int g = 0;
        if (st) store_n = 1'b0;
        if (rc) recall_n = 1'b0;
        len = 0;
        tick(1);
        while (!busy && g < 50) begin tick(1); g++; end
        while (busy && len < 5000) begin len++; tick(1); end
        store_n = 1'b1; recall_n = 1'b1; tick(4);
    endtask

    task automatic recall_model();
        for (int i = 0; i < 16; i++) m_ram[i] = m_sh[i];
        m_prv = 1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        tick(190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        finish_run();
    end

    initial begin
        int len;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 16; i++) begin m_ram[i] = init_w(i); m_sh[i] = init_w(i); end
        m_wel = 0; m_prv = 0;
        tick(5); rst_n = 1'b1; tick(2);

        // R1: reset state at the ports and initial contents.
        check(busy == 1'b0, "R1", {31'd0, busy}, 0);
        check(ser_dout == 1'b0, "R1", {31'd0, ser_dout}, 0);
        for (int i = 0; i < 16; i++) do_read(4'(i), m_ram[i], "R1");

        // R4: write blocked while write-enable latch is clear.
        do_write(4'd3, 32'h1234, 16);
        do_read(4'd3, m_ram[3], "R4");

        // R6: store without a prior user recall is dropped.
        do_cmd(3'b100); m_wel = 1;
        do_cmd(3'b001); tick(10);
        check(busy == 1'b0, "R6", {31'd0, busy}, 0);

        // R3: write then read back.
        do_write(4'd3, 32'h1234, 16); m_ram[3] = 16'h1234;
        do_read(4'd3, 16'h1234, "R3");

        // R2: leading zeros before the start bit are ignored.
        begin_frame(); send_bits(0, 5); send_bits({24'd0, 8'b1_0101_011}, 8);
        send_bits(32'hBEEF, 16); end_frame(); m_ram[5] = 16'hBEEF;
        do_read(4'd5, 16'hBEEF, "R2");

        // R12: reserved opcode keeps the latch set.
        do_cmd(3'b010);
        do_write(4'd6, 32'h0F0F, 16); m_ram[6] = 16'h0F0F;
        do_read(4'd6, 16'h0F0F, "R12");

        // R5: clear write-enable blocks writes.
        do_cmd(3'b000); m_wel = 0;
        do_write(4'd3, 32'h5555, 16);
        do_read(4'd3, 16'h1234, "R5");

        // R8: recall command restores the shadow contents.
        do_cmd(3'b101);
        check(busy == 1'b1, "R8", {31'd0, busy}, 1);
        wait_idle(); recall_model();
        do_read(4'd3, m_ram[3], "R8");

        // R7: store by pin, busy length, copy and latch clear.
        do_cmd(3'b100); m_wel = 1;
        do_write(4'd7, 32'h7777, 16); m_ram[7] = 16'h7777;
        pins_measure(1, 0, len);
        check(len == BUSY, "R7", len, BUSY);
        for (int i = 0; i < 16; i++) m_sh[i] = m_ram[i];
        m_wel = 0;
        do_write(4'd7, 32'h0001, 16);
        do_read(4'd7, 16'h7777, "R7");

        // R8: recall by pin brings back the stored word.
        do_cmd(3'b100); m_wel = 1;
        do_write(4'd7, 32'h0002, 16); m_ram[7] = 16'h0002;
        do_read(4'd7, 16'h0002, "R8");
        pins_measure(0, 1, len);
        check(len == BUSY, "R8", len, BUSY);
        recall_model();
        do_read(4'd7, 16'h7777, "R8");

        // R10: set write-enable sent during busy is ignored.
        do_cmd(3'b000); m_wel = 0;
        recall_n = 1'b0; tick(4); recall_n = 1'b1;
        do_cmd(3'b100);
        check(busy == 1'b1, "R10", {31'd0, busy}, 1);
        wait_idle(); recall_model();
        do_write(4'd8, 32'hAAAA, 16);
        do_read(4'd8, m_ram[8], "R10");

        // R11: store and recall pins fall together; recall alone runs.
        do_cmd(3'b100); m_wel = 1;
        do_write(4'd0, 32'h0BAD, 16); m_ram[0] = 16'h0BAD;
        pins_measure(1, 1, len);
        recall_model();
        do_read(4'd0, m_sh[0], "R11");
        do_write(4'd1, 32'h1111, 16); m_ram[1] = 16'h1111;
        do_read(4'd1, 16'h1111, "R11");

        // R9: short, long and empty data phases.
        do_write(4'd9, 32'h16, 5); m_ram[9] = wr_expect(32'h16, 5);
        do_read(4'd9, 16'h0016, "R9");
        do_write(4'd10, 32'hABCDE, 20); m_ram[10] = 16'hBCDE;
        do_read(4'd10, 16'hBCDE, "R9");
        do_write(4'd11, 32'h0, 0);
        do_read(4'd11, m_ram[11], "R9");

        // R13: an aborted clear-write-enable command is not executed.
        begin_frame(); send_bits(32'b10000, 5); end_frame();
        do_write(4'd4, 32'h4444, 16); m_ram[4] = 16'h4444;
        do_read(4'd4, 16'h4444, "R13");

        // R14: serial clock paused in mid-command.
        begin_frame(); send_bits(32'b111, 3); ser_clk = 1'b0; tick(300);
        send_bits(32'b00011, 5); send_bits(32'hC0DE, 16); end_frame();
        m_ram[12] = 16'hC0DE;
        do_read(4'd12, 16'hC0DE, "R14");

        // R9 and R4: random writes with random lengths and latch changes.
        for (int k = 0; k < 40; k++) begin
            int r = int'($urandom % 8);
            logic [3:0] a = 4'($urandom % 16);
            logic [31:0] d = $urandom;
            int n = int'($urandom % 25);
            if (r == 0) begin do_cmd(3'b000); m_wel = 0; end
            if (r == 1) begin do_cmd(3'b100); m_wel = 1; end
            do_write(a, d, n);
            if (m_wel && n > 0) m_ram[a] = wr_expect(d, n);
            do_read(a, m_ram[a], m_wel ? "R9" : "R4");
        end

        finish_run();
    end
endmodule